// File: doc/BRIEF.md
# 8-bit Accumulator ALU with BCD Correction

This block is the purely combinational arithmetic and logic stage of a small 8-bit processor core. Each cycle it receives an operation code, the accumulator value, a second operand and the current flag byte. It returns the new result, a strobe that says whether the result should be written back to the accumulator, and the new flag byte. Operand selection, decoding of the instruction stream, wide arithmetic and memory traffic belong to the surrounding core.

The flag byte holds four flags in its upper nibble: zero, subtract, half-carry and carry. The lower nibble is always driven as zero, and whatever arrives there is ignored. The decimal-correction operation uses the subtract, half-carry and carry flags left behind by an earlier binary add or subtract on BCD operands to bring the accumulator back into packed BCD.

Internally a small decoder turns the operation code into a bundle of strobes. That bundle drives a datapath built from a shared add/subtract unit, a logic unit and a separate BCD correction unit.

Top module: `aluCore8`

## Requirements
- R1: Code 0 (add) and code 1 (add with carry) give result (A + B + k) mod 256 with the write strobe high. k is the incoming carry for code 1 and 0 for code 0. Flags: C = sum above 255, H = (A mod 16) + (B mod 16) + k above 15, N = 0, Z = result is 0.
- R2: Code 2 (subtract) and code 3 (subtract with borrow) give result (A - B - k) mod 256 with the write strobe high. k is the incoming carry for code 3 and 0 for code 2. Flags: C = A below B + k, H = (A mod 16) below (B mod 16) + k, N = 1, Z = result is 0.
- R3: Code 4 (compare) produces the flags of code 2 for the same A and B. The write strobe stays low.
- R4: Code 5 gives A AND B with the write strobe high. Flags: Z from the result, N = 0, H = 1, C = 0.
- R5: Code 6 gives A OR B and code 7 gives A XOR B, both with the write strobe high. Flags: Z from the result, N = 0, H = 0, C = 0.
- R6: Code 8 gives the bitwise inverse of A with the write strobe high, regardless of the operand. N and H become 1, and Z and C keep their incoming values.
- R7: Code 9 sets C to 1 and code 10 inverts C. Both keep the write strobe low, clear N and H, and keep Z.
- R8: Code 11 (decimal correction) with incoming N = 0 builds a correction value. It adds 0x06 when H is set or A mod 16 is above 9, and 0x60 when C is set or A is above 0x9F. The result is (A + correction) mod 256, and C = that sum is above 255.
- R9: Code 11 with incoming N = 1 builds the correction from H alone for 0x06 and from C alone for 0x60. The result is (A - correction) mod 256, and C = correction above A.
- R10: Code 11 always writes the result. It clears H, keeps N, and sets Z when the corrected result is 0.
- R11: In both flag bytes Z is bit 7, N is bit 6, H is bit 5 and C is bit 4. Output bits 3..0 are always 0, and input bits 3..0 have no effect on any output.
- R12: Codes 12 to 15 keep the write strobe low and return the incoming flags unchanged in bits 7..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code, 0 to 15 |
| accIn | input | 8 | Accumulator value A |
| operandIn | input | 8 | Second operand B |
| flagsIn | input | 8 | Incoming flag byte |
| resultOut | output | 8 | Computed result |
| resultWe | output | 1 | High when resultOut should be written to the accumulator |
| flagsOut | output | 8 | New flag byte |

## Verification
Every output is a combinational function of the present inputs, so each result, write strobe and flag byte is due in the same cycle its stimulus is applied, with no register in the path. The bench applies each vector and lets it settle for a fixed delay before sampling. No vector overlaps the next. The sweep covers every operation code against all 256 accumulator values, a set of operands that includes the nibble and byte extremes, and all sixteen combinations of the flags. Stray bits are placed in the low nibble of the incoming flags throughout.

// File: rtl/aluCore8Pkg.sv
package aluCore8Pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;

  localparam int Z_POS = 7;
  localparam int N_POS = 6;
  localparam int H_POS = 5;
  localparam int C_POS = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_CPL = 4'd8,
    OP_SCF = 4'd9,
    OP_CCF = 4'd10,
    OP_DAA = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logicKind_e;

  typedef struct packed {
    logic       useAdder;
    logic       subMode;
    logic       carryUse;
    logic       writeEn;
    logic       useLogic;
    logicKind_e logicKind;
    logic       useCpl;
    logic       useScf;
    logic       useCcf;
    logic       useDaa;
  } aluCtrl_t;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluCore8Pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluCtrl_t        ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.logicKind = LG_AND;
    case (aluOp_e'(opSel))
      OP_ADD: begin ctrl.useAdder = 1'b1; ctrl.writeEn = 1'b1; end
      OP_ADC: begin ctrl.useAdder = 1'b1; ctrl.carryUse = 1'b1; ctrl.writeEn = 1'b1; end
      OP_SUB: begin ctrl.useAdder = 1'b1; ctrl.subMode = 1'b1; ctrl.writeEn = 1'b1; end
      OP_SBC: begin
        ctrl.useAdder = 1'b1; ctrl.subMode = 1'b1;
        ctrl.carryUse = 1'b1; ctrl.writeEn = 1'b1;
      end
      OP_CMP: begin ctrl.useAdder = 1'b1; ctrl.subMode = 1'b1; end
      OP_AND: begin ctrl.useLogic = 1'b1; ctrl.logicKind = LG_AND; ctrl.writeEn = 1'b1; end
      OP_OR:  begin ctrl.useLogic = 1'b1; ctrl.logicKind = LG_OR;  ctrl.writeEn = 1'b1; end
      OP_XOR: begin ctrl.useLogic = 1'b1; ctrl.logicKind = LG_XOR; ctrl.writeEn = 1'b1; end
      OP_CPL: begin ctrl.useCpl = 1'b1; ctrl.writeEn = 1'b1; end
      OP_SCF: ctrl.useScf = 1'b1;
      OP_CCF: ctrl.useCcf = 1'b1;
      OP_DAA: begin ctrl.useDaa = 1'b1; ctrl.writeEn = 1'b1; end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/aluAddSub.sv
module aluAddSub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         cIn,
  input  logic         subMode,
  output logic [W-1:0] sumOut,
  output logic         carryOut,
  output logic         halfOut
);
  logic [W:0]   wideSum;
  logic [NIB:0] lowSum;

  always_comb begin
    if (subMode) begin
      wideSum = {1'b0, aIn} - {1'b0, bIn} - {{W{1'b0}}, cIn};
      lowSum  = {1'b0, aIn[NIB-1:0]} - {1'b0, bIn[NIB-1:0]} - {{NIB{1'b0}}, cIn};
    end else begin
      wideSum = {1'b0, aIn} + {1'b0, bIn} + {{W{1'b0}}, cIn};
      lowSum  = {1'b0, aIn[NIB-1:0]} + {1'b0, bIn[NIB-1:0]} + {{NIB{1'b0}}, cIn};
    end
  end

  assign sumOut   = wideSum[W-1:0];
  assign carryOut = wideSum[W];
  assign halfOut  = lowSum[NIB];
endmodule

// File: rtl/aluDecAdjust.sv
module aluDecAdjust #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] accIn,
  input  logic         subFlag,
  input  logic         halfFlag,
  input  logic         carryFlag,
  output logic [W-1:0] adjOut,
  output logic         carryOut
);
  localparam logic [NIB-1:0] DIGIT_FIX = NIB'(6);
  localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);
  localparam logic [W-1:0]   HIGH_LIMIT = {DIGIT_MAX, {NIB{1'b1}}};

  logic         loFix;
  logic         hiFix;
  logic [W-1:0] corr;
  logic [W:0]   wideVal;

  assign loFix = halfFlag  | (~subFlag & (accIn[NIB-1:0] > DIGIT_MAX));
  assign hiFix = carryFlag | (~subFlag & (accIn > HIGH_LIMIT));
  assign corr  = {hiFix ? DIGIT_FIX : {NIB{1'b0}}, loFix ? DIGIT_FIX : {NIB{1'b0}}};

  always_comb begin
    if (subFlag) begin
      wideVal  = {1'b0, accIn} - {1'b0, corr};
      carryOut = corr > accIn;
    end else begin
      wideVal  = {1'b0, accIn} + {1'b0, corr};
      carryOut = wideVal[W];
    end
  end

  assign adjOut = wideVal[W-1:0];
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluCore8Pkg::*;
(
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [3:0]        flagNib,
  output logic [DATA_W-1:0] resultOut,
  output logic              resultWe,
  output logic [DATA_W-1:0] flagsOut
);
  localparam int NZ = Z_POS - C_POS;
  localparam int NN = N_POS - C_POS;
  localparam int NH = H_POS - C_POS;

  logic              zIn, nIn, hIn, cIn;
  logic [DATA_W-1:0] addSum;
  logic              addCarry, addHalf;
  logic [DATA_W-1:0] daaVal;
  logic              daaCarry;
  logic [DATA_W-1:0] logicVal;
  logic              zOut, nOut, hOut, cOut;

  assign zIn = flagNib[NZ];
  assign nIn = flagNib[NN];
  assign hIn = flagNib[NH];
  assign cIn = flagNib[0];

  aluAddSub #(.W(DATA_W), .NIB(NIB_W)) addSub_i (
    .aIn      (accIn),
    .bIn      (operandIn),
    .cIn      (ctrl.carryUse & cIn),
    .subMode  (ctrl.subMode),
    .sumOut   (addSum),
    .carryOut (addCarry),
    .halfOut  (addHalf)
  );

  aluDecAdjust #(.W(DATA_W), .NIB(NIB_W)) decAdj_i (
    .accIn     (accIn),
    .subFlag   (nIn),
    .halfFlag  (hIn),
    .carryFlag (cIn),
    .adjOut    (daaVal),
    .carryOut  (daaCarry)
  );

  always_comb begin
    case (ctrl.logicKind)
      LG_OR:   logicVal = accIn | operandIn;
      LG_XOR:  logicVal = accIn ^ operandIn;
      default: logicVal = accIn & operandIn;
    endcase
  end

  always_comb begin
    resultOut = accIn;
    zOut = zIn;
    nOut = nIn;
    hOut = hIn;
    cOut = cIn;
    if (ctrl.useAdder) begin
      resultOut = addSum;
      zOut = (addSum == '0);
      nOut = ctrl.subMode;
      hOut = addHalf;
      cOut = addCarry;
    end else if (ctrl.useLogic) begin
      resultOut = logicVal;
      zOut = (logicVal == '0);
      nOut = 1'b0;
      hOut = (ctrl.logicKind == LG_AND);
      cOut = 1'b0;
    end else if (ctrl.useCpl) begin
      resultOut = ~accIn;
      nOut = 1'b1;
      hOut = 1'b1;
    end else if (ctrl.useScf || ctrl.useCcf) begin
      nOut = 1'b0;
      hOut = 1'b0;
      cOut = ctrl.useScf ? 1'b1 : ~cIn;
    end else if (ctrl.useDaa) begin
      resultOut = daaVal;
      zOut = (daaVal == '0);
      hOut = 1'b0;
      cOut = daaCarry;
    end
  end

  always_comb begin
    flagsOut = '0;
    flagsOut[Z_POS] = zOut;
    flagsOut[N_POS] = nOut;
    flagsOut[H_POS] = hOut;
    flagsOut[C_POS] = cOut;
  end

  assign resultWe = ctrl.writeEn;
endmodule

// File: rtl/aluCore8.sv
module aluCore8
  import aluCore8Pkg::*;
(
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [DATA_W-1:0] flagsIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              resultWe,
  output logic [DATA_W-1:0] flagsOut
);
  aluCtrl_t ctrl;
  logic     unusedFlagBits;

  assign unusedFlagBits = ^flagsIn[C_POS-1:0];

  aluControl control_i (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  aluDatapath datapath_i (
    .ctrl      (ctrl),
    .accIn     (accIn),
    .operandIn (operandIn),
    .flagNib   (flagsIn[Z_POS:C_POS]),
    .resultOut (resultOut),
    .resultWe  (resultWe),
    .flagsOut  (flagsOut)
  );
endmodule

// File: rtl/aluCore8Checker.sv
module aluCore8Checker (
  input logic [3:0] opSel,
  input logic [7:0] accIn,
  input logic [7:0] operandIn,
  input logic [7:0] flagsIn,
  input logic [7:0] resultOut,
  input logic       resultWe,
  input logic [7:0] flagsOut
);
  always_comb begin
    // R11
    low_nibble_zero_chk: assert (flagsOut[3:0] == 4'h0);
    if (opSel == 4'd4) begin
      // R3
      cmp_no_write_chk: assert (!resultWe && flagsOut[6]);
    end
    if (opSel == 4'd5) begin
      // R4
      and_flags_chk: assert (flagsOut[6:4] == 3'b010 && (resultOut & ~operandIn) == 8'h00);
    end
    if (opSel == 4'd8) begin
      // R6
      cpl_invert_chk: assert (resultOut == ~accIn && flagsOut[7] == flagsIn[7] && flagsOut[4] == flagsIn[4]);
    end
    if (opSel == 4'd9) begin
      // R7
      scf_carry_chk: assert (flagsOut[4] && !resultWe && flagsOut[7] == flagsIn[7]);
    end
    if (opSel == 4'd11) begin
      // R10
      daa_half_clear_chk: assert (!flagsOut[5] && flagsOut[6] == flagsIn[6] && resultWe);
    end
    if (opSel <= 4'd3) begin
      // R1
      arith_zero_chk: assert (flagsOut[7] == (resultOut == 8'h00) && resultWe);
    end
    if (opSel >= 4'd12) begin
      // R12
      spare_code_chk: assert (!resultWe && flagsOut[7:4] == flagsIn[7:4]);
    end
  end
endmodule

bind aluCore8 aluCore8Checker chk_i (
  .opSel     (opSel),
  .accIn     (accIn),
  .operandIn (operandIn),
  .flagsIn   (flagsIn),
  .resultOut (resultOut),
  .resultWe  (resultWe),
  .flagsOut  (flagsOut)
);

// File: tb/aluCore8_tb_top.sv
module aluCore8_tb_top;
  logic       clk = 1'b0;
  logic [3:0] opSel = '0;
  logic [7:0] accIn = '0;
  logic [7:0] operandIn = '0;
  logic [7:0] flagsIn = '0;
  logic [7:0] resultOut;
  logic       resultWe;
  logic [7:0] flagsOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aluCore8 dut_i (
    .opSel     (opSel),
    .accIn     (accIn),
    .operandIn (operandIn),
    .flagsIn   (flagsIn),
    .resultOut (resultOut),
    .resultWe  (resultWe),
    .flagsOut  (flagsOut)
  );

  function automatic string tagOf(int op, bit nFlag);
    case (op)
      0, 1:  return "R1";
      2, 3:  return "R2";
      4:     return "R3";
      5:     return "R4";
      6, 7:  return "R5";
      8:     return "R6";
      9, 10: return "R7";
      11:    return nFlag ? "R9" : "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic runVec(int op, int a, int b, int fl);
    int  k, s, r, adj;
    bit  z, n, h, c, zN, nN, hN, cN, we;
    logic [7:0] expF;
    string tag;
    z = fl[7]; n = fl[6]; h = fl[5]; c = fl[4];
    zN = z; nN = n; hN = h; cN = c; we = 0; r = a;
    case (op)
      0, 1: begin
        k = (op == 1) ? int'(c) : 0;
        s = a + b + k; r = s % 256; we = 1;
        cN = s > 255; hN = ((a % 16) + (b % 16) + k) > 15; nN = 0; zN = (r == 0);
      end
      2, 3, 4: begin
        k = (op == 3) ? int'(c) : 0;
        s = a - b - k; r = (s + 256) % 256; we = (op != 4);
        cN = s < 0; hN = ((a % 16) - (b % 16) - k) < 0; nN = 1; zN = (r == 0);
      end
      5, 6, 7: begin
        r = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
        we = 1; zN = (r == 0); nN = 0; hN = (op == 5); cN = 0;
      end
      8: begin r = 255 - a; we = 1; nN = 1; hN = 1; end
      9:  begin nN = 0; hN = 0; cN = 1; end
      10: begin nN = 0; hN = 0; cN = !c; end
      11: begin
        adj = 0; we = 1;
        if (n) begin
          if (h) adj += 6;
          if (c) adj += 96;
          cN = adj > a; r = (a - adj + 256) % 256;
        end else begin
          if (h || (a % 16) > 9) adj += 6;
          if (c || a > 159) adj += 96;
          s = a + adj; cN = s > 255; r = s % 256;
        end
        zN = (r == 0); hN = 0;
      end
      default: ;
    endcase
    expF = {zN, nN, hN, cN, 4'h0};
    opSel = op[3:0]; accIn = a[7:0]; operandIn = b[7:0]; flagsIn = fl[7:0];
    #1;
    tag = tagOf(op, n);
    checks++;
    if (resultWe !== we) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h write strobe %0b expected %0b", tag, op, a, b, fl, resultWe, we);
    end
    if (we) begin
      checks++;
      if (resultOut !== r[7:0]) begin
        errors++;
        $display("FAIL %s op=%0d a=%02h b=%02h f=%02h result %02h expected %02h", tag, op, a, b, fl, resultOut, r[7:0]);
      end
    end
    if (op == 11) tag = "R10";
    checks++;
    if (flagsOut[7:4] !== expF[7:4]) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h flags %02h expected %02h", tag, op, a, b, fl, flagsOut, expF);
    end
    // R11: low nibble of the flag byte always zero, stray input bits ignored
    checks++;
    if (flagsOut[3:0] !== 4'h0) begin
      errors++;
      $display("FAIL R11 op=%0d f=%02h low nibble %01h expected 0", op, fl, flagsOut[3:0]);
    end
  endtask

  initial begin
    int bSet[6] = '{0, 15, 16, 153, 240, 255};
    #1;
    for (int op = 0; op < 16; op++) begin
      for (int fh = 0; fh < 16; fh++) begin
        for (int a = 0; a < 256; a++) begin
          for (int bi = 0; bi < 6; bi++) begin
            runVec(op, a, bSet[bi], fh * 16 + ((a ^ bSet[bi]) % 16));
          end
        end
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the sweep finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule